// File: doc/BRIEF.md
# Dual Gated Timer/Counter Unit

This block holds two 16-bit count channels, numbered 0 and 1, driven from one system clock. Each channel either times internal machine cycles, where one machine cycle is twelve clock periods, or counts falling edges seen on its own external pin. An optional gate makes counting depend on the level of that same pin. Software sets the unit up through a small byte-wide register port. One shared mode register holds a 4-bit configuration nibble per channel. One shared control register holds the run bits and the sticky overflow flags. Four further byte registers expose the low and high halves of each count.

Each channel's nibble picks one of four count shapes. The first is a 13-bit count: a 5-bit prescaler in the low byte feeds an 8-bit high byte. The second is a full 16-bit count. The third is an 8-bit low byte that reloads from the high byte each time it overflows. The fourth splits channel 0 into two independent 8-bit counters and freezes channel 1. External pins pass through a two-flop synchroniser. Each pin then feeds a two-state sampling machine with states `SMP_LOW` and `SMP_HIGH`. The machine moves only on a machine-cycle tick. The `SMP_HIGH -> SMP_LOW` transition taken on a tick is the falling-edge event. The `SMP_LOW -> SMP_HIGH` transition on a tick records a high level. With no tick, or with the sample equal to the state, the machine stays where it is. The per-channel mode decode is an enumerated selector with the states `MODE_13B`, `MODE_16B`, `MODE_RELOAD` and `MODE_SPLIT`, and it picks the next-count logic.

Top module: `tmr_dual_unit`

## Requirements
- R1: After reset, every register reads 0x00 and both overflow outputs are 0.
- R2: Register addresses are 0 = mode, 1 = control, 2 = channel 0 low byte, 3 = channel 0 high byte, 4 = channel 1 low byte, 5 = channel 1 high byte. Addresses 6 and 7 read 0x00. Reads are combinational from the current register contents. Control bit 0 is run for channel 0 and bit 1 is run for channel 1. Control bit 4 is the overflow flag of channel 0 and bit 5 is the overflow flag of channel 1. The other control bits read 0.
- R3: In timer mode with run set, a channel advances exactly once per 12 clocks, on the clock edge where the free-running divide-by-12 phase counter wraps. With run clear, the count holds.
- R4: In counter mode, the pin is synchronised through two flops and sampled on each machine-cycle tick. One count is made when a tick's sample is 0 and the previous tick's sample was 1. A pin that holds each level for at least two machine cycles is counted once per falling edge.
- R5: Mode nibbles sit at bits 7:4 for channel 1 and bits 3:0 for channel 0. Within a nibble, bit 3 is gate, bit 2 selects the external pin (1) or the machine cycle (0), and bits 1:0 are the mode. With gate set, a channel counts only while the most recent tick's sample of its pin is 1.
- R6: Mode 00 increments bits 4:0 of the low byte. The low byte's bits 7:5 are kept. A carry out of bit 4 increments the high byte, and a high-byte wrap to 0x00 raises overflow.
- R7: Mode 01 counts over all 16 bits and raises overflow on the wrap from 0xFFFF to 0x0000.
- R8: Mode 10 increments the low byte. On an increment from 0xFF, the low byte loads the high byte and overflow is raised. The high byte is not changed by counting.
- R9: When channel 0's mode is 11, its low byte is an 8-bit counter under channel 0's run, gate and source, and its overflow goes to flag 0. Its high byte counts machine cycles under channel 1's run bit, and its overflow goes to flag 1. When channel 1's mode is 11, channel 1 holds its count.
- R10: An overflow sets the channel's flag, and the flag stays set. A write to the control register loads both flags from bits 5:4 of the written data, and that write takes precedence over an overflow in the same cycle.
- R11: A write to either count byte of a channel loads that byte and suppresses every increment and overflow of that channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at `reg_addr` |
| ext_in | input | 2 | External count/gate pins, bit n for channel n |
| ovf_flag | output | 2 | Sticky overflow flags, bit n for channel n |

## Verification
Three situations are hard to reach from the ports: a register write or a control write landing in the very cycle of a machine-cycle tick, and a falling edge that is seen only once the synchroniser and the tick phase line up. The stimulus repeats the same write on twelve or more consecutive cycles, so one write always coincides with a tick. It also holds each pin level for two machine cycles, so the sampler sees every edge whatever the phase. A behavioural model run on every clock then confirms the exact cycle in which each byte and flag changes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_CH     = 2;
    localparam int ADDR_W     = 3;
    localparam int BYTE_W     = 8;

    localparam logic [ADDR_W-1:0] ADDR_MODE     = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT_BASE = 3'd2;

    typedef enum logic [1:0] {
        MODE_13B    = 2'b00,
        MODE_16B    = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } tmr_mode_e;

    typedef enum logic {
        SMP_LOW  = 1'b0,
        SMP_HIGH = 1'b1
    } smp_state_e;

    typedef struct packed {
        logic      gate;
        logic      ext_sel;
        tmr_mode_e mode;
    } chan_cfg_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == LAST);

    // R3: a machine-cycle tick never lasts two clocks in a row
    assert_tick_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3: the phase counter stays inside its divide range
    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);

endmodule

// File: rtl/tmr_edge_fsm.sv
module tmr_edge_fsm
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sampled;
    smp_state_e             state_q;
    smp_state_e             state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
        end
    end

    assign sampled = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SMP_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMP_LOW:  if (tick && sampled)  state_d = SMP_HIGH;
            SMP_HIGH: if (tick && !sampled) state_d = SMP_LOW;
            default:  state_d = SMP_LOW;
        endcase
    end

    always_comb begin
        level = 1'b0;
        fall  = 1'b0;
        unique case (state_q)
            SMP_LOW:  level = 1'b0;
            SMP_HIGH: begin
                level = 1'b1;
                fall  = tick && !sampled;
            end
            default:  level = 1'b0;
        endcase
    end

    // R4: an edge event always leaves the sampler in the low state
    assert_fall_lands_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (state_q == SMP_LOW));

    // R4: the sampled state only moves on a tick
    assert_state_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter bit HAS_SPLIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              inc,
    input  logic              inc_split,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic              ovf_main,
    output logic              ovf_split
);
    logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
    logic [5:0]        pre_sum;
    logic [BYTE_W:0]   hi_sum;
    logic [BYTE_W:0]   lo_sum;
    logic [2*BYTE_W:0] wide_sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    always_comb begin
        lo_d      = lo_q;
        hi_d      = hi_q;
        ovf_main  = 1'b0;
        ovf_split = 1'b0;
        pre_sum   = {1'b0, lo_q[4:0]} + 6'd1;
        hi_sum    = {1'b0, hi_q} + 9'd1;
        lo_sum    = {1'b0, lo_q} + 9'd1;
        wide_sum  = {1'b0, hi_q, lo_q} + 17'd1;
        if (wr_lo || wr_hi) begin
            if (wr_lo) lo_d = wdata;
            if (wr_hi) hi_d = wdata;
        end else begin
            unique case (mode)
                MODE_13B: begin
                    if (inc) begin
                        lo_d = {lo_q[7:5], pre_sum[4:0]};
                        if (pre_sum[5]) begin
                            hi_d     = hi_sum[BYTE_W-1:0];
                            ovf_main = hi_sum[BYTE_W];
                        end
                    end
                end
                MODE_16B: begin
                    if (inc) begin
                        {hi_d, lo_d} = wide_sum[2*BYTE_W-1:0];
                        ovf_main     = wide_sum[2*BYTE_W];
                    end
                end
                MODE_RELOAD: begin
                    if (inc) begin
                        if (lo_sum[BYTE_W]) begin
                            lo_d     = hi_q;
                            ovf_main = 1'b1;
                        end else begin
                            lo_d = lo_sum[BYTE_W-1:0];
                        end
                    end
                end
                MODE_SPLIT: begin
                    if (HAS_SPLIT) begin
                        if (inc) begin
                            lo_d     = lo_sum[BYTE_W-1:0];
                            ovf_main = lo_sum[BYTE_W];
                        end
                        if (inc_split) begin
                            hi_d      = hi_sum[BYTE_W-1:0];
                            ovf_split = hi_sum[BYTE_W];
                        end
                    end
                end
                default: begin
                    lo_d = lo_q;
                end
            endcase
        end
    end

    assign cnt_lo = lo_q;
    assign cnt_hi = hi_q;

    // R11: a low-byte write lands even when an increment is due
    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo_q == $past(wdata)));

    // R3: with no increment request and no write the count holds
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !inc_split && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

    // R8: the reload path never changes the high byte
    assert_reload_keeps_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RELOAD && !wr_hi) |=> $stable(hi_q));

endmodule

// File: rtl/tmr_dual_unit.sv
module tmr_dual_unit
    import tmr_pkg::*;
#(
    parameter int PRESCALE    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [BYTE_W-1:0]     reg_wdata,
    output logic [BYTE_W-1:0]     reg_rdata,
    input  logic [NUM_CH-1:0]     ext_in,
    output logic [NUM_CH-1:0]     ovf_flag
);
    logic [BYTE_W-1:0] mode_q;
    logic [NUM_CH-1:0] run_q;
    logic [NUM_CH-1:0] flag_q;
    logic [NUM_CH-1:0] flag_src;
    logic              tick;
    logic              ctrl_wr;
    logic              split_inc;

    logic [NUM_CH-1:0] pin_level;
    logic [NUM_CH-1:0] pin_fall;
    logic [NUM_CH-1:0] chan_inc;
    logic [NUM_CH-1:0] ovf_main;
    logic [NUM_CH-1:0] ovf_split;
    logic [BYTE_W-1:0] cnt_lo [NUM_CH];
    logic [BYTE_W-1:0] cnt_hi [NUM_CH];

    tmr_prescale #(.DIV(PRESCALE)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
    assign split_inc = tick && run_q[1];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_LO = ADDR_CNT_BASE + ADDR_W'(2 * c);
        localparam logic [ADDR_W-1:0] A_HI = ADDR_CNT_BASE + ADDR_W'(2 * c + 1);

        chan_cfg_t cfg;
        logic      source_ev;
        logic      gate_ok;

        assign cfg       = chan_cfg_t'(mode_q[4*c +: 4]);
        assign source_ev = cfg.ext_sel ? pin_fall[c] : tick;
        assign gate_ok   = !cfg.gate || pin_level[c];
        assign chan_inc[c] = run_q[c] && gate_ok && source_ev;

        tmr_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .pin   (ext_in[c]),
            .level (pin_level[c]),
            .fall  (pin_fall[c])
        );

        tmr_chan #(.HAS_SPLIT(c == 0)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (cfg.mode),
            .inc       (chan_inc[c]),
            .inc_split ((c == 0) ? split_inc : 1'b0),
            .wr_lo     (reg_wr && (reg_addr == A_LO)),
            .wr_hi     (reg_wr && (reg_addr == A_HI)),
            .wdata     (reg_wdata),
            .cnt_lo    (cnt_lo[c]),
            .cnt_hi    (cnt_hi[c]),
            .ovf_main  (ovf_main[c]),
            .ovf_split (ovf_split[c])
        );
    end

    assign flag_src[0] = ovf_main[0];
    assign flag_src[1] = ovf_main[1] | ovf_split[0] | ovf_split[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (reg_wr && (reg_addr == ADDR_MODE)) begin
                mode_q <= reg_wdata;
            end
            if (ctrl_wr) begin
                run_q  <= reg_wdata[1:0];
                flag_q <= reg_wdata[5:4];
            end else begin
                flag_q <= flag_q | flag_src;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            3'd0:    reg_rdata = mode_q;
            3'd1:    reg_rdata = {2'b00, flag_q, 2'b00, run_q};
            3'd2:    reg_rdata = cnt_lo[0];
            3'd3:    reg_rdata = cnt_hi[0];
            3'd4:    reg_rdata = cnt_lo[1];
            3'd5:    reg_rdata = cnt_hi[1];
            default: reg_rdata = '0;
        endcase
    end

    assign ovf_flag = flag_q;

    // R10: a raised flag stays up until the control register is written
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !ctrl_wr) |=> flag_q[0]);

    // R10: a control write loads the flags from its data, overriding overflow
    assert_ctrl_loads_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ovf_flag == $past(reg_wdata[5:4])));

    // R3: with both channels stopped no flag can rise
    assert_no_flag_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == 2'b00 && !ctrl_wr && !$isunknown(flag_q)) |=> $stable(flag_q));

endmodule

// File: tb/tmr_dual_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_dual_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [1:0] ext_in = 2'b00;
    logic [1:0] ovf_flag;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    finished = 1'b0;

    always #4 clk = ~clk;

    tmr_dual_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ext_in    (ext_in),
        .ovf_flag  (ovf_flag)
    );

    // behavioural reference model
    int m_mode, m_run, m_flag, m_pre;
    int m_lo[2], m_hi[2], m_s1[2], m_s2[2], m_samp[2];

    function automatic int model_read(input int a);
        case (a)
            0: return m_mode;
            1: return (m_flag << 4) | m_run;
            2: return m_lo[0];
            3: return m_hi[0];
            4: return m_lo[1];
            5: return m_hi[1];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_run = 0; m_flag = 0; m_pre = 0;
            for (int c = 0; c < 2; c++) begin
                m_lo[c] = 0; m_hi[c] = 0; m_s1[c] = 0; m_s2[c] = 0; m_samp[c] = 0;
            end
        end else begin
            bit tk;
            bit en[2];
            bit en_split;
            int ov;
            tk = (m_pre == 11);
            for (int c = 0; c < 2; c++) begin
                int nib;
                bit fl;
                nib = (m_mode >> (4 * c)) & 15;
                fl = tk && (m_samp[c] == 1) && (m_s2[c] == 0);
                en[c] = ((m_run >> c) & 1) == 1 && (((nib >> 3) & 1) == 0 || m_samp[c] == 1)
                        && ((((nib >> 2) & 1) == 1) ? fl : tk);
            end
            en_split = tk && ((m_run >> 1) & 1) == 1;
            ov = 0;
            for (int c = 0; c < 2; c++) begin
                int md;
                md = (m_mode >> (4 * c)) & 3;
                if (reg_wr && (reg_addr == 3'(2 + 2 * c) || reg_addr == 3'(3 + 2 * c))) begin
                    if (reg_addr == 3'(2 + 2 * c)) m_lo[c] = reg_wdata;
                    else m_hi[c] = reg_wdata;
                end else if (md == 0) begin
                    if (en[c]) begin
                        int p;
                        p = (m_lo[c] & 31) + 1;
                        if (p == 32) begin
                            p = 0;
                            m_hi[c] = m_hi[c] + 1;
                            if (m_hi[c] == 256) begin m_hi[c] = 0; ov |= (1 << c); end
                        end
                        m_lo[c] = (m_lo[c] & 224) | p;
                    end
                end else if (md == 1) begin
                    if (en[c]) begin
                        int v;
                        v = m_hi[c] * 256 + m_lo[c] + 1;
                        if (v == 65536) begin v = 0; ov |= (1 << c); end
                        m_hi[c] = v / 256; m_lo[c] = v % 256;
                    end
                end else if (md == 2) begin
                    if (en[c]) begin
                        if (m_lo[c] == 255) begin m_lo[c] = m_hi[c]; ov |= (1 << c); end
                        else m_lo[c] = m_lo[c] + 1;
                    end
                end else if (c == 0) begin
                    if (en[0]) begin
                        m_lo[0] = (m_lo[0] + 1) % 256;
                        if (m_lo[0] == 0) ov |= 1;
                    end
                    if (en_split) begin
                        m_hi[0] = (m_hi[0] + 1) % 256;
                        if (m_hi[0] == 0) ov |= 2;
                    end
                end
            end
            if (reg_wr && reg_addr == 3'd0) m_mode = reg_wdata;
            if (reg_wr && reg_addr == 3'd1) begin
                m_run = reg_wdata & 3;
                m_flag = (reg_wdata >> 4) & 3;
            end else begin
                m_flag = m_flag | ov;
            end
            m_pre = tk ? 0 : m_pre + 1;
            for (int c = 0; c < 2; c++) begin
                if (tk) m_samp[c] = m_s2[c];
                m_s2[c] = m_s1[c];
                m_s1[c] = ext_in[c];
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(cur_req, int'(reg_rdata), model_read(int'(reg_addr)));
            check(cur_req, int'(ovf_flag), m_flag);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        step();
        reg_addr  = 3'(a);
        reg_wdata = 8'(d);
        reg_wr    = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            reg_wr   = 1'b0;
            reg_addr = reg_addr + 3'd1;
        end
    endtask

    task automatic readchk(input string req, input int a, input int exp);
        step();
        reg_wr   = 1'b0;
        reg_addr = 3'(a);
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1 / R2: reset values across the whole map
        cur_req = "R1";
        for (int a = 0; a < 8; a++) readchk("R1", a, 0);
        check("R1", int'(ovf_flag), 0);

        // R2: write and read back mode and count bytes
        cur_req = "R2";
        wr(0, 8'hA5); readchk("R2", 0, 8'hA5);
        wr(5, 8'h3C); readchk("R2", 5, 8'h3C);
        wr(0, 0); wr(5, 0);
        readchk("R2", 6, 0);

        // R3: ch0 16-bit timer, 120 edges with run set -> 10 counts
        cur_req = "R3";
        wr(0, 8'h01); wr(2, 0); wr(3, 0);
        wr(1, 8'h01); idle(119); wr(1, 8'h00);
        readchk("R3", 2, 10);
        idle(40);
        readchk("R3", 2, 10);

        // R7: 16-bit wrap sets flag 0
        cur_req = "R7";
        wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h01); idle(36);
        check("R7", int'(ovf_flag[0]), 1);
        wr(1, 8'h00);

        // R6: ch1 13-bit, low 0x1E / high 0xFF, 3 ticks
        cur_req = "R6";
        wr(0, 8'h00); wr(4, 8'hFE); wr(5, 8'hFF); wr(1, 8'h02); idle(36);
        check("R6", int'(ovf_flag[1]), 1);
        readchk("R6", 5, 8'h00);
        wr(1, 8'h00);

        // R8: ch0 reload, 5 ticks from 0xFE with reload 0xF0
        cur_req = "R8";
        wr(0, 8'h02); wr(3, 8'hF0); wr(2, 8'hFE); wr(1, 8'h01); idle(60);
        readchk("R8", 2, 8'hF3);
        check("R8", int'(ovf_flag[0]), 1);
        readchk("R8", 3, 8'hF0);
        wr(1, 8'h00);

        // R4: ch1 external falling edges, 5 pulses
        cur_req = "R4";
        wr(0, 8'h50); wr(4, 0); wr(5, 0); wr(1, 8'h02);
        for (int i = 0; i < 5; i++) begin
            ext_in[1] = 1'b1; idle(24);
            ext_in[1] = 1'b0; idle(24);
        end
        idle(48);
        readchk("R4", 4, 5);
        wr(1, 8'h00);

        // R5: gated ch0 timer, pin low blocks, pin high counts
        cur_req = "R5";
        ext_in[0] = 1'b0;
        wr(0, 8'h09); wr(2, 0); wr(3, 0); wr(1, 8'h01); idle(60);
        readchk("R5", 2, 0);
        ext_in[0] = 1'b1; idle(60);
        ext_in[0] = 1'b0; idle(60);
        wr(1, 8'h00);

        // R9: split mode, both halves count, ch1 frozen
        cur_req = "R9";
        wr(0, 8'h33); wr(2, 8'hFD); wr(3, 8'hFE); wr(4, 8'h11); wr(1, 8'h03); idle(36);
        readchk("R9", 2, 8'h00);
        check("R9", int'(ovf_flag), 3);
        idle(30);
        readchk("R9", 4, 8'h11);
        wr(1, 8'h00);

        // R11: repeated low-byte write beats every tick
        cur_req = "R11";
        wr(0, 8'h01); wr(3, 0); wr(1, 8'h01);
        for (int i = 0; i < 24; i++) wr(2, 8'h80);
        readchk("R11", 2, 8'h80);
        wr(1, 8'h00);

        // R10: control write clears flag even on overflow cycles, then sticky
        cur_req = "R10";
        wr(0, 8'h02); wr(3, 8'hFF); wr(2, 8'hFF);
        for (int i = 0; i < 24; i++) wr(1, 8'h01);
        step(); reg_wr = 1'b0; #1;
        check("R10", int'(ovf_flag[0]), 0);
        idle(24);
        check("R10", int'(ovf_flag[0]), 1);
        wr(1, 8'h00);
        idle(30);
        check("R10", int'(ovf_flag[0]), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule